// File: doc/BRIEF.md
# Split Accurate/Inaccurate Approximate Adder

A combinational 16-bit adder that gives up exactness in its low-order bits to keep the longest carry path short. The operands are split at a parameter `ACC_W` (m). The upper m bits go through an exact ripple-carry sub-adder, which also produces the carry-out. The lower 16-m bits have no carries at all: each sum bit is the XOR of its operand bits. The exception is a round-up chain that starts at any low position where both operands are 1. That position and every less significant bit of the sum are driven to 1.

The exact sub-adder never receives a carry from the low part, and the external carry-in is not used. The result is therefore never larger than the exact sum a+b. It falls short of it by less than 2^(16-m). The block suits datapaths that tolerate frequent small errors in the low bits in exchange for a carry chain only m bits long.

Top module: `apx_split_adder`

## Requirements
- R1: `sum_o[15:16-m]` equals `(a_i[15:16-m] + b_i[15:16-m])` modulo 2^m, computed with a carry-in of 0, for m in {4, 6, 8, 10, 12} (default 8).
- R2: `cout_o` is the carry out of that m-bit upper addition and nothing else.
- R3: For a low bit i (i < 16-m), if no position j with i <= j < 16-m has both operand bits set, `sum_o[i]` equals `a_i[i] ^ b_i[i]`.
- R4: For a low bit i, if any position j with i <= j < 16-m has both operand bits set, `sum_o[i]` is 1.
- R5: `cin_i` has no effect: both outputs are the same for `cin_i` = 0 and 1 with equal operands.
- R6: When no low position has both operand bits set, the 17-bit value `{cout_o, sum_o}` equals the exact sum `a_i + b_i`.
- R7: `{cout_o, sum_o}` is never below `a_i + b_i - 2^(16-m)`.
- R8: `{cout_o, sum_o}` never exceeds `a_i + b_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry-in; ignored by this architecture |
| sum_o | output | 16 | Approximate sum |
| cout_o | output | 1 | Carry out of the exact upper part |

## Verification
The checker's assertions assume fully known 2-state operands. They also assume the outputs have settled to their combinational value whenever they are evaluated. The bench therefore changes operands only on the falling clock edge and samples 2 ns later, well before the next change. The stimulus covers the case with no low-part generate, which must be exact. It places a single generate at the top and at the bottom of the low part, and it uses all-ones operands. A seeded xorshift sweep covers the rest of the operand space, and every vector in the sweep is also checked against the error bounds.

// File: rtl/apx_split_adder_pkg.sv
package apx_split_adder_pkg;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic              cout;
        logic [DATA_W-1:0] sum;
    } apx_result_t;
endpackage

// File: rtl/apx_fa.sv
module apx_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    always_comb begin
        s_o = x_i ^ y_i ^ c_i;
        c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
    end
endmodule

// File: rtl/apx_ripple.sv
module apx_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);
    logic [W:0] carry;

    assign carry[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_bit
        apx_fa u_fa (
            .x_i (x_i[k]),
            .y_i (y_i[k]),
            .c_i (carry[k]),
            .s_o (s_o[k]),
            .c_o (carry[k+1])
        );
    end

    assign c_o = carry[W];
endmodule

// File: rtl/apx_roundup.sv
module apx_roundup #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o
);
    logic [W-1:0] gen;
    logic [W-1:0] force_hi;

    assign gen = x_i & y_i;

    // force_hi[k] is set when a generate sits at k or any position above it
    assign force_hi[W-1] = gen[W-1];
    for (genvar k = W - 2; k >= 0; k--) begin : g_chain
        assign force_hi[k] = gen[k] | force_hi[k+1];
    end

    for (genvar k = 0; k < W; k++) begin : g_sum
        assign s_o[k] = force_hi[k] | (x_i[k] ^ y_i[k]);
    end
endmodule

// File: rtl/apx_split_adder.sv
module apx_split_adder
    import apx_split_adder_pkg::*;
#(
    parameter int ACC_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);
    localparam int LOW_W = DATA_W - ACC_W;

    logic [ACC_W-1:0] hi_sum;
    logic             hi_carry;
    logic [LOW_W-1:0] lo_sum;
    logic             cin_unused;
    apx_result_t      res_d;

    assign cin_unused = cin_i;

    apx_ripple #(.W(ACC_W)) u_exact (
        .x_i (a_i[DATA_W-1:LOW_W]),
        .y_i (b_i[DATA_W-1:LOW_W]),
        .s_o (hi_sum),
        .c_o (hi_carry)
    );

    apx_roundup #(.W(LOW_W)) u_approx (
        .x_i (a_i[LOW_W-1:0]),
        .y_i (b_i[LOW_W-1:0]),
        .s_o (lo_sum)
    );

    always_comb begin
        res_d.cout = hi_carry;
        res_d.sum  = {hi_sum, lo_sum};
    end

    assign sum_o  = res_d.sum;
    assign cout_o = res_d.cout;
endmodule

// File: rtl/apx_split_adder_chk.sv
module apx_split_adder_chk #(
    parameter int ACC_W = 8
) (
    input logic [15:0] a_i,
    input logic [15:0] b_i,
    input logic [15:0] sum_o,
    input logic        cout_o
);
    localparam int LOW_W = 16 - ACC_W;

    logic [ACC_W:0]   hi_ref;
    logic [LOW_W-1:0] gen;
    logic [17:0]      exact;
    logic [17:0]      approx;

    assign hi_ref = {1'b0, a_i[15:LOW_W]} + {1'b0, b_i[15:LOW_W]};
    assign gen    = a_i[LOW_W-1:0] & b_i[LOW_W-1:0];
    assign exact  = {2'b00, a_i} + {2'b00, b_i};
    assign approx = {1'b0, cout_o, sum_o};

    always_comb begin
        a_r1_upper_sum: assert (sum_o[15:LOW_W] == hi_ref[ACC_W-1:0])
            else $error("R1 upper sum mismatch");
        a_r2_carry_out: assert (cout_o == hi_ref[ACC_W])
            else $error("R2 carry-out mismatch");
        for (int i = 0; i < LOW_W; i++) begin
            if ((gen >> i) != '0) begin
                a_r4_round_up: assert (sum_o[i])
                    else $error("R4 bit %0d not forced", i);
            end else begin
                a_r3_xor_bit: assert (sum_o[i] == (a_i[i] ^ b_i[i]))
                    else $error("R3 bit %0d not xor", i);
            end
        end
        if (gen == '0) begin
            a_r6_exact: assert (approx == exact)
                else $error("R6 not exact without generate");
        end
        a_r7_lower_bound: assert (approx + (18'd1 << LOW_W) >= exact)
            else $error("R7 error too large");
        a_r8_upper_bound: assert (approx <= exact)
            else $error("R8 result above exact sum");
    end
endmodule

bind apx_split_adder apx_split_adder_chk #(.ACC_W(ACC_W)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/apx_split_adder_tb.sv
`timescale 1ns/1ps
module apx_split_adder_tb;
    localparam int M = 8;
    localparam int L = 16 - M;

    logic        clk = 1'b0;
    logic [15:0] a, b;
    logic        cin;
    logic [15:0] sum;
    logic        cout;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #4 clk = ~clk;

    apx_split_adder #(.ACC_W(M)) u_dut (
        .a_i (a), .b_i (b), .cin_i (cin), .sum_o (sum), .cout_o (cout)
    );

    function automatic logic [16:0] model(input logic [15:0] x, input logic [15:0] y);
        logic [M:0]   hi;
        logic [L-1:0] lo;
        logic         f;
        hi = {1'b0, x[15:L]} + {1'b0, y[15:L]};
        f  = 1'b0;
        for (int i = L - 1; i >= 0; i--) begin
            f     = f | (x[i] & y[i]);
            lo[i] = f | (x[i] ^ y[i]);
        end
        return {hi, lo};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c);
        @(negedge clk);
        a = x; b = y; cin = c;
        #2;
    endtask

    task automatic check_model(input string tag);
        logic [16:0] e;
        e = model(a, b);
        check({cout, sum} == e, tag, {cout, sum}, e);
    endtask

    task automatic t_zero();
        apply(16'h0000, 16'h0000, 1'b0);
        check({cout, sum} == 17'h0, "R6 zero operands", {cout, sum}, 17'h0);
    endtask

    task automatic t_no_generate();
        apply(16'h12F0, 16'h340F, 1'b0);
        check({cout, sum} == 17'h046FF, "R6 disjoint low bits exact", {cout, sum}, 17'h046FF);
        check(sum[L-1:0] == 8'hFF, "R3 xor low bits", {9'h0, sum[L-1:0]}, 17'hFF);
        apply(16'hFF55, 16'h01AA, 1'b0);
        check({cout, sum} == 17'h100FF, "R2 carry from upper part", {cout, sum}, 17'h100FF);
    endtask

    task automatic t_generate_top();
        apply(16'h0080, 16'h0080, 1'b0);
        check({cout, sum} == 17'h000FF, "R4 generate at top of low part", {cout, sum}, 17'h000FF);
        apply(16'h1234, 16'h4321, 1'b0);
        check({cout, sum} == 17'h0553F, "R4 generate at bit 5", {cout, sum}, 17'h0553F);
    endtask

    task automatic t_generate_lsb();
        apply(16'h0001, 16'h0001, 1'b0);
        check({cout, sum} == 17'h00001, "R4 generate at bit 0 only", {cout, sum}, 17'h00001);
        check(sum[L-1:1] == '0, "R3 bits above generate stay xor", {10'h0, sum[L-1:1]}, 17'h0);
    endtask

    task automatic t_all_ones();
        apply(16'hFFFF, 16'hFFFF, 1'b0);
        check({cout, sum} == 17'h1FEFF, "R1 all-ones operands", {cout, sum}, 17'h1FEFF);
        check(cout == 1'b1, "R2 all-ones carry-out", {16'h0, cout}, 17'h1);
    endtask

    task automatic t_cin_ignored();
        logic [16:0] r0;
        apply(16'hA5C3, 16'h3C5A, 1'b0);
        r0 = {cout, sum};
        apply(16'hA5C3, 16'h3C5A, 1'b1);
        check({cout, sum} == r0, "R5 cin has no effect", {cout, sum}, r0);
        check_model("R5 cin=1 matches model");
        apply(16'h00F0, 16'h000F, 1'b1);
        check({cout, sum} == 17'h000FF, "R5 cin not added", {cout, sum}, 17'h000FF);
    endtask

    task automatic t_sweep();
        logic [31:0] s;
        logic [17:0] ex, ap;
        s = 32'h1234_5678;
        for (int n = 0; n < 4000; n++) begin
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            apply(s[15:0], s[31:16], s[7]);
            check_model("R1 R2 R3 R4 sweep vs model");
            ex = {2'b00, a} + {2'b00, b};
            ap = {1'b0, cout, sum};
            check(ap + (18'd1 << L) >= ex, "R7 lower error bound", ap[16:0], ex[16:0]);
            check(ap <= ex, "R8 never above exact", ap[16:0], ex[16:0]);
        end
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        t_zero();
        t_no_generate();
        t_generate_top();
        t_generate_lsb();
        t_all_ones();
        t_cin_ignored();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule